// File: doc/BRIEF.md
# Receiver Polling Mode Sequencer

This block steps a low-power radio receiver through a repeating duty cycle: a programmable sleep interval, a fixed warm-up of the analog front end, a signal-check window judged by an external check unit, and finally reception. All phase timing is counted in half-period ticks of a divided base clock, so the sleep interval and the warm-up length follow the base clock rate and not the fast system clock.

A failed signal check sends the receiver back to sleep. When a check passes, a polling-mode input chooses what happens next. In one setting the sequencer enters reception directly. In the other it raises an interrupt and holds the front end ready until the host acknowledges. Once the sequencer is receiving, only a new operating-mode write from the host moves it out of that phase. Such a write aborts any phase on the next clock edge.

Top module: `rx_poll_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `phase` is 0 (idle) and `irq`, `fe_en`, `chk_en` and `rx_active` are 0.
- R2: A cycle with `mode_wr` high puts `phase` at idle (0) on the next edge, from any phase. If the written `mode_poll_on` was 1, the sequencer moves from idle to sleep (1) on the edge after that. If it was 0, the sequencer stays idle.
- R3: Sleep (`phase` 1) lasts U*2048 ticks of `half_tick`, where U is `sleep_val`. A `sleep_val` of 0 counts as 1. Both values are taken at sleep entry. After sleep the phase becomes warm-up (2).
- R4: With `sleep_ext` = 1 at sleep entry, the sleep length is multiplied by 8.
- R5: Warm-up (`phase` 2) lasts 1597 ticks of `half_tick`, which is 798.5 base periods. Cycles without a tick do not advance it. After warm-up the phase becomes check (3).
- R6: In check, a cycle with `chk_done`=1 and `chk_pass`=0 returns the phase to sleep (1) on the next edge.
- R7: In check, `chk_done`=1 and `chk_pass`=1 with `poll_mode`=1 move the phase to receive (5) on the next edge, and `irq` stays 0.
- R8: In check, `chk_done`=1 and `chk_pass`=1 with `poll_mode`=0 move the phase to host-wait (4) and set `irq` on the next edge. Host-wait persists until a cycle with `irq_clr`=1. That edge moves the phase to receive (5) and clears `irq`.
- R9: In receive, `rx_bit_err` has no effect. The phase stays 5 until a mode write.
- R10: The outputs follow the phase. `fe_en` is 1 in phases 2, 3, 4 and 5. `chk_en` is 1 only in phase 3. `rx_active` is 1 in phases 2, 3 and 5. `irq` is 1 exactly in phase 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle pulse per half base-clock period |
| mode_wr | input | 1 | Host operating-mode write strobe |
| mode_poll_on | input | 1 | Written mode: 1 runs the polling loop, 0 stays idle |
| sleep_val | input | 5 | Sleep length in 1024-base-period units |
| sleep_ext | input | 1 | Multiplies sleep length by 8 |
| poll_mode | input | 1 | 1: pass enters receive directly; 0: interrupt and wait |
| chk_done | input | 1 | Check unit has a verdict this cycle |
| chk_pass | input | 1 | Verdict: 1 pass, 0 fail |
| irq_clr | input | 1 | Host acknowledge / interrupt clear |
| rx_bit_err | input | 1 | Bit error seen during reception |
| phase | output | 3 | Current phase code (0 idle, 1 sleep, 2 warm-up, 3 check, 4 host-wait, 5 receive) |
| fe_en | output | 1 | Analog front-end enable |
| chk_en | output | 1 | Enables the external check unit |
| rx_active | output | 1 | Receiver-active flag |
| irq | output | 1 | Interrupt to host |

## Verification
The bench measures each phase's exact length in cycles and compares it with the computed value. This catches an off-by-one in the 2048-tick unit count or the 1597-tick warm-up, a zero sleep value that gives a zero-length or wrapped interval, and an extension factor applied wrongly. A tick gap in warm-up checks that the timer counts ticks and not clock cycles. Each check outcome is driven both ways. A design that confused the polling-mode polarity would skip or spuriously raise the interrupt, and one that left host-wait without an acknowledge would reach receive early. Bit errors during receive and a mode write during warm-up and sleep are also driven: a design that treated a bit error as an abort, or that ignored a mid-phase mode write, would show the wrong phase sequence.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;

    localparam int DEF_SLEEP_W    = 5;
    localparam int DEF_UNIT_HALF  = 2048;
    localparam int DEF_EXT_FACTOR = 8;
    localparam int DEF_WARM_HALF  = 1597;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SLEEP = 3'd1,
        PH_WARM  = 3'd2,
        PH_CHECK = 3'd3,
        PH_HOLD  = 3'd4,
        PH_RECV  = 3'd5
    } phase_e;

    typedef struct packed {
        logic fe_en;
        logic chk_en;
        logic rx_active;
    } fe_ctl_t;

    function automatic fe_ctl_t decode_phase(phase_e p);
        fe_ctl_t c;
        c.fe_en     = (p == PH_WARM) || (p == PH_CHECK) || (p == PH_HOLD) || (p == PH_RECV);
        c.chk_en    = (p == PH_CHECK);
        c.rx_active = (p == PH_WARM) || (p == PH_CHECK) || (p == PH_RECV);
        return c;
    endfunction

    function automatic bit is_pow2(int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/rx_poll_sleep_timer.sv
module rx_poll_sleep_timer
    import rx_poll_pkg::*;
#(
    parameter int SLEEP_W    = DEF_SLEEP_W,
    parameter int UNIT_HALF  = DEF_UNIT_HALF,
    parameter int EXT_FACTOR = DEF_EXT_FACTOR
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               run,
    input  logic               tick,
    input  logic [SLEEP_W-1:0] val,
    input  logic               ext,
    output logic               done
);
    localparam int MAX_UNITS = ((1 << SLEEP_W) - 1) * EXT_FACTOR;
    localparam int UNIT_W    = $clog2(MAX_UNITS + 1);
    localparam int PRE_W     = $clog2(UNIT_HALF);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_HALF - 1);

    logic [UNIT_W-1:0] base_units;
    logic [UNIT_W-1:0] load_units;
    logic [UNIT_W-1:0] units_q;
    logic [PRE_W-1:0]  pre_q;

    // zero is promoted to the minimum of one unit
    always_comb begin
        base_units = (val == '0) ? UNIT_W'(1) : UNIT_W'(val);
    end

    generate
        if (is_pow2(EXT_FACTOR)) begin : g_ext_shift
            localparam int SHIFT = $clog2(EXT_FACTOR);
            always_comb load_units = ext ? (base_units << SHIFT) : base_units;
        end else begin : g_ext_mult
            always_comb load_units = ext ? (base_units * UNIT_W'(EXT_FACTOR)) : base_units;
        end
    endgenerate

    assign done = run && tick && (pre_q == PRE_LAST) && (units_q == UNIT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            units_q <= '0;
            pre_q   <= '0;
        end else if (load) begin
            units_q <= load_units;
            pre_q   <= '0;
        end else if (run && tick) begin
            if (pre_q == PRE_LAST) begin
                pre_q   <= '0;
                units_q <= units_q - UNIT_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    AST_SLEEP_UNITS_NZ: assert property (@(posedge clk) disable iff (rst)
        run |-> (units_q != '0)); // R3

    AST_SLEEP_EXT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load && ext) |=> (units_q >= UNIT_W'(EXT_FACTOR))); // R4

endmodule

// File: rtl/rx_poll_warm_timer.sv
module rx_poll_warm_timer
    import rx_poll_pkg::*;
#(
    parameter int WARM_HALF = DEF_WARM_HALF
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int WARM_W = $clog2(WARM_HALF);
    localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(WARM_HALF - 1);

    logic [WARM_W-1:0] cnt_q;

    assign done = run && tick && (cnt_q == WARM_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (run && tick && (cnt_q != WARM_LAST)) begin
            cnt_q <= cnt_q + WARM_W'(1);
        end
    end

    AST_WARM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !load) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/rx_poll_irq_flag.sv
module rx_poll_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)      irq <= 1'b0;
        else if (set) irq <= 1'b1;
        else if (clr) irq <= 1'b0;
    end

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !irq); // R8

endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq
    import rx_poll_pkg::*;
#(
    parameter int SLEEP_W    = DEF_SLEEP_W,
    parameter int UNIT_HALF  = DEF_UNIT_HALF,
    parameter int EXT_FACTOR = DEF_EXT_FACTOR,
    parameter int WARM_HALF  = DEF_WARM_HALF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               half_tick,
    input  logic               mode_wr,
    input  logic               mode_poll_on,
    input  logic [SLEEP_W-1:0] sleep_val,
    input  logic               sleep_ext,
    input  logic               poll_mode,
    input  logic               chk_done,
    input  logic               chk_pass,
    input  logic               irq_clr,
    input  logic               rx_bit_err,
    output logic [2:0]         phase,
    output logic               fe_en,
    output logic               chk_en,
    output logic               rx_active,
    output logic               irq
);
    phase_e  ph_q, ph_nxt;
    logic    poll_on_q;
    logic    sleep_done, warm_done;
    logic    sleep_load, warm_load;
    logic    irq_set;
    fe_ctl_t ctl;

    always_ff @(posedge clk) begin
        if (rst)          poll_on_q <= 1'b0;
        else if (mode_wr) poll_on_q <= mode_poll_on;
    end

    always_comb begin
        ph_nxt = ph_q;
        if (mode_wr) begin
            ph_nxt = PH_IDLE;
        end else begin
            unique case (ph_q)
                PH_IDLE:  if (poll_on_q)  ph_nxt = PH_SLEEP;
                PH_SLEEP: if (sleep_done) ph_nxt = PH_WARM;
                PH_WARM:  if (warm_done)  ph_nxt = PH_CHECK;
                PH_CHECK: if (chk_done)
                              ph_nxt = !chk_pass ? PH_SLEEP : (poll_mode ? PH_RECV : PH_HOLD);
                PH_HOLD:  if (irq_clr)    ph_nxt = PH_RECV;
                PH_RECV:  ph_nxt = PH_RECV;
                default:  ph_nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_nxt;
    end

    assign sleep_load = (ph_nxt == PH_SLEEP) && (ph_q != PH_SLEEP);
    assign warm_load  = (ph_nxt == PH_WARM)  && (ph_q != PH_WARM);
    assign irq_set    = (ph_q == PH_CHECK) && chk_done && chk_pass && !poll_mode && !mode_wr;

    rx_poll_sleep_timer #(
        .SLEEP_W    (SLEEP_W),
        .UNIT_HALF  (UNIT_HALF),
        .EXT_FACTOR (EXT_FACTOR)
    ) u_sleep (
        .clk  (clk),
        .rst  (rst),
        .load (sleep_load),
        .run  (ph_q == PH_SLEEP),
        .tick (half_tick),
        .val  (sleep_val),
        .ext  (sleep_ext),
        .done (sleep_done)
    );

    rx_poll_warm_timer #(
        .WARM_HALF (WARM_HALF)
    ) u_warm (
        .clk  (clk),
        .rst  (rst),
        .load (warm_load),
        .run  (ph_q == PH_WARM),
        .tick (half_tick),
        .done (warm_done)
    );

    rx_poll_irq_flag u_irq (
        .clk (clk),
        .rst (rst),
        .set (irq_set),
        .clr (irq_clr || mode_wr),
        .irq (irq)
    );

    always_comb ctl = decode_phase(ph_q);

    assign phase     = ph_q;
    assign fe_en     = ctl.fe_en;
    assign chk_en    = ctl.chk_en;
    assign rx_active = ctl.rx_active;

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (phase == 3'd0) && !irq); // R1

    AST_MODE_ABORT: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (phase == 3'd0)); // R2

    AST_WARM_STAYS: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd2) && !half_tick && !mode_wr |=> (phase == 3'd2)); // R5

    AST_FAIL_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3) && chk_done && !chk_pass && !mode_wr |=> (phase == 3'd1)); // R6

    AST_DIRECT_RX: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3) && chk_done && chk_pass && poll_mode && !mode_wr
        |=> (phase == 3'd5) && !irq); // R7

    AST_HOLD_IRQ: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3) && chk_done && chk_pass && !poll_mode && !mode_wr
        |=> (phase == 3'd4) && irq); // R8

    AST_RX_STICKY: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd5) && rx_bit_err && !mode_wr |=> (phase == 3'd5)); // R9

    AST_CHK_EN_ONLY: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chk_en, irq})); // R10

endmodule

// File: tb/rx_poll_seq_tb.sv
module rx_poll_seq_tb;

    typedef struct {
        int    st;
        int    dur;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_tick = 1'b1;
    logic       mode_wr = 1'b0;
    logic       mode_poll_on = 1'b0;
    logic [4:0] sleep_val = 5'd1;
    logic       sleep_ext = 1'b0;
    logic       poll_mode = 1'b1;
    logic       chk_done = 1'b0;
    logic       chk_pass = 1'b0;
    logic       irq_clr = 1'b0;
    logic       rx_bit_err = 1'b0;
    logic [2:0] phase;
    logic       fe_en, chk_en, rx_active, irq;

    int   tests = 0;
    int   fails = 0;
    exp_t q[$];
    int   prev_st = 0;
    int   run_len = 0;

    always #2.5 clk = ~clk;

    rx_poll_seq u_dut (
        .clk(clk), .rst(rst), .half_tick(half_tick), .mode_wr(mode_wr),
        .mode_poll_on(mode_poll_on), .sleep_val(sleep_val), .sleep_ext(sleep_ext),
        .poll_mode(poll_mode), .chk_done(chk_done), .chk_pass(chk_pass),
        .irq_clr(irq_clr), .rx_bit_err(rx_bit_err), .phase(phase), .fe_en(fe_en),
        .chk_en(chk_en), .rx_active(rx_active), .irq(irq)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(int st, int dur, string tag);
        exp_t e;
        e.st = st; e.dur = dur; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_phase(int st);
        do @(negedge clk); while (int'(phase) != st);
    endtask

    task automatic mode_write(bit on);
        mode_wr = 1'b1; mode_poll_on = on;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    // called at the first negedge of the check phase: check lasts 4 samples
    task automatic verdict(bit pass);
        repeat (3) @(negedge clk);
        chk_done = 1'b1; chk_pass = pass;
        @(negedge clk);
        chk_done = 1'b0; chk_pass = 1'b0;
    endtask

    // scoreboard monitor: phase lengths and per-phase outputs (R10)
    always @(negedge clk) begin
        if (!rst) begin
            if (int'(phase) == prev_st) begin
                run_len++;
            end else begin
                if (q.size() == 0) begin
                    check(1'b0, "scoreboard empty", int'(phase), -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.st == prev_st, {e.tag, " phase order"}, prev_st, e.st);
                    if (e.dur != 0)
                        check(run_len == e.dur, {e.tag, " phase length"}, run_len, e.dur);
                end
                check(fe_en == (phase >= 3'd2 && phase <= 3'd5), "R10 fe_en", fe_en, phase);
                check(chk_en == (phase == 3'd3), "R10 chk_en", chk_en, phase);
                check(rx_active == (phase == 3'd2 || phase == 3'd3 || phase == 3'd5),
                      "R10 rx_active", rx_active, phase);
                check(irq == (phase == 3'd4), "R10 irq", irq, phase);
                prev_st = int'(phase);
                run_len = 1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(phase == 3'd0, "R1 phase in reset", phase, 0);
        check({irq, fe_en, chk_en, rx_active} == 4'b0, "R1 outputs in reset",
              {irq, fe_en, chk_en, rx_active}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(phase == 3'd0, "R1 phase after reset", phase, 0);

        // pass 1: direct receive, failure retry, tick gap
        sleep_val = 5'd1; sleep_ext = 1'b0; poll_mode = 1'b1;
        push(0, 0, "R2");
        push(1, 2048, "R3");
        push(2, 1597, "R5");
        push(3, 4, "R6");
        push(1, 2048, "R6");
        push(2, 1607, "R5");
        push(3, 4, "R7");
        push(5, 0, "R9");
        push(0, 0, "R2");
        mode_write(1'b1);
        wait_phase(3);
        verdict(1'b0);
        wait_phase(2);
        repeat (100) @(negedge clk);
        half_tick = 1'b0;
        repeat (10) @(negedge clk);
        half_tick = 1'b1;
        wait_phase(3);
        verdict(1'b1);
        check(phase == 3'd5, "R7 receive entered", phase, 5);
        check(irq == 1'b0, "R7 no interrupt", irq, 0);
        rx_bit_err = 1'b1;
        repeat (5) @(negedge clk);
        rx_bit_err = 1'b0;
        @(negedge clk);
        check(phase == 3'd5, "R9 bit error ignored", phase, 5);
        mode_write(1'b0);
        repeat (20) @(negedge clk);
        check(phase == 3'd0, "R2 stays idle when mode off", phase, 0);

        // pass 2: zero sleep value, interrupt path, restart, extension, aborts
        sleep_val = 5'd0; poll_mode = 1'b0;
        push(1, 2048, "R3");
        push(2, 1597, "R5");
        push(3, 4, "R8");
        push(4, 0, "R8");
        push(5, 0, "R8");
        push(0, 1, "R2");
        push(1, 6144, "R3");
        push(2, 1597, "R5");
        push(3, 4, "R6");
        push(1, 32768, "R4");
        push(2, 51, "R2");
        push(0, 1, "R2");
        push(1, 100, "R2");
        push(0, 0, "R2");
        mode_write(1'b1);
        wait_phase(3);
        verdict(1'b1);
        check(phase == 3'd4, "R8 host-wait entered", phase, 4);
        check(irq == 1'b1, "R8 interrupt raised", irq, 1);
        repeat (20) @(negedge clk);
        check(phase == 3'd4 && irq, "R8 waits for host", phase, 4);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check(phase == 3'd5, "R8 receive after clear", phase, 5);
        check(irq == 1'b0, "R8 interrupt cleared", irq, 0);
        sleep_val = 5'd3;
        repeat (5) @(negedge clk);
        mode_write(1'b1);
        wait_phase(3);
        sleep_val = 5'd2; sleep_ext = 1'b1;
        verdict(1'b0);
        wait_phase(2);
        repeat (50) @(negedge clk);
        mode_write(1'b1);
        wait_phase(1);
        repeat (99) @(negedge clk);
        mode_write(1'b0);
        repeat (20) @(negedge clk);
        check(phase == 3'd0, "R2 abort from sleep", phase, 0);
        check(q.size() == 1, "R2 scoreboard drained", q.size(), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule